// File: doc/BRIEF.md
# Supply-Monitor Reset Controller

This block turns two digitised supply comparators into the chip's reset and early-warning signals. One comparator says whether the supply is above the reset threshold. The other says whether it is above the higher warning threshold. Both are synchronised and filtered against glitches. When the monitor is enabled and chosen as a reset source, a supply dip holds the active-low reset low. After the supply recovers, the reset is held low for a further programmable stretch before it is released.

Software controls the block through a few strobes. It can write the monitor enable and select bits and a warning-interrupt enable, request a software reset, and enter or leave sleep. It can also acknowledge the warning interrupt and clear cause flags by writing ones. A flash erase or write attempted while the monitor is off forces a reset, and that reset is recorded as a flash-error cause.

The monitor bits follow two rules. A software reset leaves them unchanged, while a power-on or supply reset forces them back on. Sleep turns the monitor off and blocks supply resets. Waking restores the bits that software last wrote.

Top module: `supply_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_n` is 0, `cause` is 2'b01, `mon_en` and `mon_sel` are 1, and `asleep`, `vdd_ok` and `warn_irq` are 0. The interrupt enable is cleared.
- R2: Suppose `mon_en` and `mon_sel` are 1, the block is awake, and the filtered reset comparator reads 0. Then `rst_n` is low in the next cycle and `cause` becomes 2'b01. The monitor bits, and the remembered software values of those bits, are all set to 1.
- R3: Every reset event holds `rst_n` low while its condition lasts. It then keeps `rst_n` low for STRETCH_CYC (default 16) more cycles and releases it.
- R4: A software reset request drives `rst_n` low for STRETCH_CYC cycles and sets `cause` to 2'b00. It leaves `mon_en` and `mon_sel` as software last wrote them.
- R5: A sleep request sets `asleep` and reads `mon_en` and `mon_sel` as 0. While asleep, a low supply causes no reset. A wake request clears `asleep` and restores the monitor bits that software last wrote.
- R6: `vdd_ok` follows the filtered warning comparator.
- R7: While the interrupt enable is 1 and `vdd_ok` is 0, `warn_irq` is set. Once set, it stays set until `irq_ack`. An acknowledgement clears it for one cycle, and it sets again if the condition still holds.
- R8: A `flash_op` strobe while `mon_en` is 0 starts a reset with `cause` 2'b10. While `mon_en` is 1, the strobe has no effect.
- R9: Each comparator passes through two synchronising flops, and a new level must be seen for two cycles in a row. A change driven before edge k reaches the block's decisions at edge k+3. A pulse one cycle long is ignored.
- R10: At most one `cause` bit is set, where bit 0 means power-on or supply and bit 1 means flash error. Writing 1s on `cause_clr` clears the matching bits.
- R11: While `rst_n` is 0 or `asleep` is 1, the block ignores `cfg_we`, `cause_clr`, `flash_op`, `sw_rst_req` and `sleep_req`.
- R12: The priority is: supply reset, then flash error, then software reset, then the cause clear applied together with sleep or configuration, then sleep, then configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| cmp_rst_ok | input | 1 | Supply above reset threshold |
| cmp_warn_ok | input | 1 | Supply above warning threshold |
| sw_rst_req | input | 1 | Software reset request |
| sleep_req | input | 1 | Enter sleep |
| wake_req | input | 1 | Leave sleep |
| flash_op | input | 1 | Flash erase/write strobe |
| cfg_we | input | 1 | Write monitor and interrupt-enable bits |
| cfg_mon_en | input | 1 | Monitor enable write data |
| cfg_mon_sel | input | 1 | Monitor reset-source select write data |
| cfg_irq_en | input | 1 | Warning interrupt enable write data |
| cause_clr | input | 2 | Write-1-to-clear mask for cause |
| irq_ack | input | 1 | Warning interrupt acknowledge |
| rst_n | output | 1 | Active-low system reset |
| cause | output | 2 | Reset cause: bit0 supply/power-on, bit1 flash error |
| mon_en | output | 1 | Monitor enable as applied |
| mon_sel | output | 1 | Monitor reset-source select as applied |
| vdd_ok | output | 1 | Supply above warning threshold |
| warn_irq | output | 1 | Warning interrupt |
| asleep | output | 1 | Sleep state |

## Verification
Some properties are checked on every cycle:
- `rst_n` falls in the cycle after a monitored supply dip.
- A flash strobe with the monitor off always yields a flash-error reset.
- Sleep never coincides with reset.
- The cause flags stay at most one-hot.
- The warning interrupt follows its enabled level condition.

Other behaviour needs the bench's scenarios:
- the monitor bits surviving a software reset and being restored on wake;
- glitch rejection;
- the exact stretch length;
- priority between simultaneous requests;
- inputs ignored during reset and sleep.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

    localparam logic [1:0] CAUSE_NONE   = 2'b00;
    localparam logic [1:0] CAUSE_SUPPLY = 2'b01;
    localparam logic [1:0] CAUSE_FLASH  = 2'b10;

    typedef struct packed {
        logic       mon_en;
        logic       mon_sel;
        logic       usr_en;
        logic       usr_sel;
        logic       irq_en;
        logic       irq;
        logic       asleep;
        logic [1:0] cause;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        mon_en:  1'b1,
        mon_sel: 1'b1,
        usr_en:  1'b1,
        usr_sel: 1'b1,
        irq_en:  1'b0,
        irq:     1'b0,
        asleep:  1'b0,
        cause:   CAUSE_SUPPLY
    };

endpackage

// File: rtl/srm_sync_filter.sv
module srm_sync_filter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] flt_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
        logic [W-1:0] flt;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.s1   = raw_i;
        f_d.s2   = f_q.s1;
        f_d.prev = f_q.s2;
        for (int i = 0; i < W; i++) begin
            if (f_q.s2[i] == f_q.prev[i]) begin
                f_d.flt[i] = f_q.s2[i];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flt_o = f_q.flt;

endmodule

// File: rtl/srm_stretch.sv
module srm_stretch #(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold_i,
    input  logic start_i,
    output logic active_o
);

    localparam int CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold_i || start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= LOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/supply_rst_ctrl.sv
module supply_rst_ctrl
    import supply_rst_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       cmp_rst_ok,
    input  logic       cmp_warn_ok,
    input  logic       sw_rst_req,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       flash_op,
    input  logic       cfg_we,
    input  logic       cfg_mon_en,
    input  logic       cfg_mon_sel,
    input  logic       cfg_irq_en,
    input  logic [1:0] cause_clr,
    input  logic       irq_ack,
    output logic       rst_n,
    output logic [1:0] cause,
    output logic       mon_en,
    output logic       mon_sel,
    output logic       vdd_ok,
    output logic       warn_irq,
    output logic       asleep
);

    ctl_t st_d, st_q;
    logic [1:0] flt;
    logic rst_ok_f;
    logic warn_ok_f;
    logic hold;
    logic start;
    logic sw_ok;
    logic rst_active;
    logic irq_en_w;

    srm_sync_filter #(.W(2)) u_filt (
        .clk   (clk),
        .por_n (por_n),
        .raw_i ({cmp_warn_ok, cmp_rst_ok}),
        .flt_o (flt)
    );

    assign rst_ok_f  = flt[0];
    assign warn_ok_f = flt[1];

    srm_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk      (clk),
        .por_n    (por_n),
        .hold_i   (hold),
        .start_i  (start),
        .active_o (rst_active)
    );

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        hold  = st_q.mon_en && st_q.mon_sel && !st_q.asleep && !rst_ok_f;
        sw_ok = !rst_active && !st_q.asleep;

        if (hold) begin
            st_d.cause   = CAUSE_SUPPLY;
            st_d.mon_en  = 1'b1;
            st_d.mon_sel = 1'b1;
            st_d.usr_en  = 1'b1;
            st_d.usr_sel = 1'b1;
        end else if (sw_ok) begin
            if (flash_op && !st_q.mon_en) begin
                start      = 1'b1;
                st_d.cause = CAUSE_FLASH;
            end else if (sw_rst_req) begin
                start      = 1'b1;
                st_d.cause = CAUSE_NONE;
            end else begin
                st_d.cause = st_q.cause & ~cause_clr;
                if (sleep_req) begin
                    st_d.asleep  = 1'b1;
                    st_d.mon_en  = 1'b0;
                    st_d.mon_sel = 1'b0;
                end else if (cfg_we) begin
                    st_d.usr_en  = cfg_mon_en;
                    st_d.usr_sel = cfg_mon_sel;
                    st_d.mon_en  = cfg_mon_en;
                    st_d.mon_sel = cfg_mon_sel;
                    st_d.irq_en  = cfg_irq_en;
                end
            end
        end else if (st_q.asleep && wake_req) begin
            st_d.asleep  = 1'b0;
            st_d.mon_en  = st_q.usr_en;
            st_d.mon_sel = st_q.usr_sel;
        end

        if (irq_ack) begin
            st_d.irq = 1'b0;
        end else begin
            st_d.irq = st_q.irq || (st_q.irq_en && !warn_ok_f);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_en_w = st_q.irq_en;
    assign rst_n    = !rst_active;
    assign cause    = st_q.cause;
    assign mon_en   = st_q.mon_en;
    assign mon_sel  = st_q.mon_sel;
    assign vdd_ok   = warn_ok_f;
    assign warn_irq = st_q.irq;
    assign asleep   = st_q.asleep;

endmodule

// File: rtl/srm_checker.sv
module srm_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic [1:0] cause,
    input logic       mon_en,
    input logic       mon_sel,
    input logic       asleep,
    input logic       vdd_ok,
    input logic       warn_irq,
    input logic       rst_ok_f,
    input logic       irq_en,
    input logic       irq_ack,
    input logic       flash_op
);

    assert_supply_dip_resets_R2: assert property (@(posedge clk) disable iff (!por_n)
        (mon_en && mon_sel && !asleep && !rst_ok_f) |=> (!rst_n && cause == 2'b01));

    assert_flash_error_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && !asleep && !mon_en && flash_op) |=> (!rst_n && cause == 2'b10));

    assert_cause_exclusive_R10: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause));

    assert_sleep_no_reset_R5: assert property (@(posedge clk) disable iff (!por_n)
        asleep |-> rst_n);

    assert_warn_irq_level_R7: assert property (@(posedge clk) disable iff (!por_n)
        (irq_en && !vdd_ok && !irq_ack) |=> warn_irq);

endmodule

bind supply_rst_ctrl srm_checker u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .cause    (cause),
    .mon_en   (mon_en),
    .mon_sel  (mon_sel),
    .asleep   (asleep),
    .vdd_ok   (vdd_ok),
    .warn_irq (warn_irq),
    .rst_ok_f (rst_ok_f),
    .irq_en   (irq_en_w),
    .irq_ack  (irq_ack),
    .flash_op (flash_op)
);

// File: tb/supply_rst_ctrl_tb_top.sv
module supply_rst_ctrl_tb_top;

    localparam int STRETCH = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic por_n, cmp_rst_ok, cmp_warn_ok, sw_rst_req, sleep_req, wake_req;
    logic flash_op, cfg_we, cfg_mon_en, cfg_mon_sel, cfg_irq_en, irq_ack;
    logic [1:0] cause_clr;
    logic rst_n, mon_en, mon_sel, vdd_ok, warn_irq, asleep;
    logic [1:0] cause;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    supply_rst_ctrl #(.STRETCH_CYC(STRETCH)) dut_i (
        .clk(clk), .por_n(por_n), .cmp_rst_ok(cmp_rst_ok), .cmp_warn_ok(cmp_warn_ok),
        .sw_rst_req(sw_rst_req), .sleep_req(sleep_req), .wake_req(wake_req),
        .flash_op(flash_op), .cfg_we(cfg_we), .cfg_mon_en(cfg_mon_en),
        .cfg_mon_sel(cfg_mon_sel), .cfg_irq_en(cfg_irq_en), .cause_clr(cause_clr),
        .irq_ack(irq_ack), .rst_n(rst_n), .cause(cause), .mon_en(mon_en),
        .mon_sel(mon_sel), .vdd_ok(vdd_ok), .warn_irq(warn_irq), .asleep(asleep)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit m_fr, m_fw, m_en, m_sel, m_uen, m_usel, m_ien, m_irq, m_sleep;
    bit [1:0] m_cause;
    int m_cnt;
    bit qr[$];
    bit qw[$];
    bit m_hold, m_ok, m_trig, m_nirq;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_fr = 0; m_fw = 0; m_en = 1; m_sel = 1; m_uen = 1; m_usel = 1;
            m_ien = 0; m_irq = 0; m_sleep = 0; m_cause = 2'b01; m_cnt = STRETCH;
            qr = '{0, 0, 0};
            qw = '{0, 0, 0};
        end else begin
            m_hold = m_en && m_sel && !m_sleep && !m_fr;
            m_ok   = (m_cnt == 0) && !m_sleep;
            m_trig = 0;
            m_nirq = irq_ack ? 1'b0 : (m_irq || (m_ien && !m_fw));
            if (m_hold) begin
                m_cause = 2'b01; m_en = 1; m_sel = 1; m_uen = 1; m_usel = 1;
            end else if (m_ok) begin
                if (flash_op && !m_en) begin
                    m_trig = 1; m_cause = 2'b10;
                end else if (sw_rst_req) begin
                    m_trig = 1; m_cause = 2'b00;
                end else begin
                    m_cause = m_cause & ~cause_clr;
                    if (sleep_req) begin
                        m_sleep = 1; m_en = 0; m_sel = 0;
                    end else if (cfg_we) begin
                        m_uen = cfg_mon_en; m_usel = cfg_mon_sel;
                        m_en = cfg_mon_en; m_sel = cfg_mon_sel; m_ien = cfg_irq_en;
                    end
                end
            end else if (m_sleep && wake_req) begin
                m_sleep = 0; m_en = m_uen; m_sel = m_usel;
            end
            m_irq = m_nirq;
            if (m_hold || m_trig) m_cnt = STRETCH;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (qr[1] == qr[0]) m_fr = qr[1];
            if (qw[1] == qw[0]) m_fw = qw[1];
            qr.push_back(cmp_rst_ok); void'(qr.pop_front());
            qw.push_back(cmp_warn_ok); void'(qw.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check("R3 model rst_n", {3'b0, rst_n}, {3'b0, (m_cnt == 0)});
            check("R10 model cause", {2'b0, cause}, {2'b0, m_cause});
            check("R4 model mon_en", {3'b0, mon_en}, {3'b0, m_en});
            check("R4 model mon_sel", {3'b0, mon_sel}, {3'b0, m_sel});
            check("R6 model vdd_ok", {3'b0, vdd_ok}, {3'b0, m_fw});
            check("R7 model warn_irq", {3'b0, warn_irq}, {3'b0, m_irq});
            check("R5 model asleep", {3'b0, asleep}, {3'b0, m_sleep});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit en, input bit sel, input bit ie);
        cfg_we = 1; cfg_mon_en = en; cfg_mon_sel = sel; cfg_irq_en = ie;
        cyc(1);
        cfg_we = 0;
    endtask

    initial begin
        por_n = 0; cmp_rst_ok = 1; cmp_warn_ok = 1; sw_rst_req = 0; sleep_req = 0;
        wake_req = 0; flash_op = 0; cfg_we = 0; cfg_mon_en = 0; cfg_mon_sel = 0;
        cfg_irq_en = 0; cause_clr = 2'b00; irq_ack = 0;
        cyc(3);
        check("R1 rst_n", {3'b0, rst_n}, 4'd0);
        check("R1 cause", {2'b0, cause}, 4'd1);
        check("R1 mon_en", {3'b0, mon_en}, 4'd1);
        check("R1 mon_sel", {3'b0, mon_sel}, 4'd1);
        check("R1 irq", {3'b0, warn_irq}, 4'd0);
        por_n = 1;
        cyc(10);
        check("R3 stretch holds", {3'b0, rst_n}, 4'd0);
        cyc(20);
        check("R3 released", {3'b0, rst_n}, 4'd1);
        check("R6 vdd_ok", {3'b0, vdd_ok}, 4'd1);

        cfg(0, 0, 0);
        check("R4 prep mon_en", {3'b0, mon_en}, 4'd0);
        sw_rst_req = 1; cyc(1); sw_rst_req = 0;
        check("R4 sw reset", {3'b0, rst_n}, 4'd0);
        check("R4 cause none", {2'b0, cause}, 4'd0);
        cfg(1, 1, 0);
        check("R11 cfg ignored in reset", {3'b0, mon_en}, 4'd0);
        cyc(20);
        check("R4 released", {3'b0, rst_n}, 4'd1);
        check("R4 mon_en kept", {3'b0, mon_en}, 4'd0);
        check("R4 mon_sel kept", {3'b0, mon_sel}, 4'd0);

        flash_op = 1; cyc(1); flash_op = 0;
        check("R8 flash reset", {3'b0, rst_n}, 4'd0);
        check("R8 flash cause", {2'b0, cause}, 4'd2);
        cyc(20);
        cause_clr = 2'b10; cyc(1); cause_clr = 2'b00;
        check("R10 w1c", {2'b0, cause}, 4'd0);

        flash_op = 1; sw_rst_req = 1; cyc(1); flash_op = 0; sw_rst_req = 0;
        check("R12 flash over sw", {2'b0, cause}, 4'd2);
        cyc(20);

        cfg(1, 1, 1);
        flash_op = 1; cyc(1); flash_op = 0;
        check("R8 monitored flash ok", {3'b0, rst_n}, 4'd1);

        cmp_rst_ok = 0; cyc(1); cmp_rst_ok = 1;
        cyc(6);
        check("R9 glitch ignored", {3'b0, rst_n}, 4'd1);
        cmp_rst_ok = 0;
        cyc(2);
        check("R9 sync latency", {3'b0, rst_n}, 4'd1);
        cyc(3);
        check("R2 supply reset", {3'b0, rst_n}, 4'd0);
        check("R2 cause", {2'b0, cause}, 4'd1);
        cmp_rst_ok = 1;
        cyc(10);
        check("R3 stretch after recovery", {3'b0, rst_n}, 4'd0);
        cyc(15);
        check("R3 release after recovery", {3'b0, rst_n}, 4'd1);

        cmp_warn_ok = 0; cyc(6);
        check("R6 vdd_ok low", {3'b0, vdd_ok}, 4'd0);
        check("R7 irq set", {3'b0, warn_irq}, 4'd1);
        irq_ack = 1; cyc(1); irq_ack = 0;
        check("R7 ack clears", {3'b0, warn_irq}, 4'd0);
        cyc(1);
        check("R7 level reasserts", {3'b0, warn_irq}, 4'd1);
        cmp_warn_ok = 1; cyc(6);
        check("R7 pending after recovery", {3'b0, warn_irq}, 4'd1);
        irq_ack = 1; cyc(1); irq_ack = 0; cyc(2);
        check("R7 cleared", {3'b0, warn_irq}, 4'd0);

        sleep_req = 1; cyc(1); sleep_req = 0;
        check("R5 asleep", {3'b0, asleep}, 4'd1);
        check("R5 mon off in sleep", {3'b0, mon_en}, 4'd0);
        cmp_rst_ok = 0; cyc(10);
        check("R5 no reset in sleep", {3'b0, rst_n}, 4'd1);
        flash_op = 1; cyc(1); flash_op = 0; cyc(1);
        check("R11 flash ignored asleep", {3'b0, rst_n}, 4'd1);
        cmp_rst_ok = 1; cyc(6);
        wake_req = 1; cyc(1); wake_req = 0;
        check("R5 awake", {3'b0, asleep}, 4'd0);
        check("R5 mon_en restored", {3'b0, mon_en}, 4'd1);
        check("R5 mon_sel restored", {3'b0, mon_sel}, 4'd1);
        cyc(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule